// File: doc/BRIEF.md
# Input Clock Frequency Band Detector

This block sorts an incoming clock into one of six frequency bands, each an octave above the last, and produces the power-of-two factor that a downstream clock multiplier needs to bring that input into a fixed output range. It can take the band from two static three-level range selects (strap mode). When both selects sit at the middle level, it measures the band itself instead (auto mode).

In auto mode a free-running Gray-coded counter tallies rising edges of the measured clock in that clock's own domain. The timebase domain samples the counter through a two-flop synchronizer. Each gate window lasts a fixed number of timebase cycles. At the end of each window the difference between snapshots is compared against six count windows, which are derived from parameters. A new band is accepted only when two consecutive windows agree. A window that matches no band clears the valid flag and leaves the band index where it was.

A third static code picks the output range. The low range targets about 155–167 MHz. The middle and high ranges target about 622–667 MHz. The factor follows from the band and this range.

Top module: `fbd_band_detect`

## Requirements
- R1: The tri-level codes are LOW=0, MID=1, HIGH=2; code 3 is undefined. Strap pairs (sel_a,sel_b) map to bands as follows: (H,H)→0, (H,L)→1, (M,H)→2, (M,L)→3, (L,H)→4, (L,L)→5.
- R2: The pairs (H,M) and (L,M), and any pair with a select at code 3, set code_invalid=1 and band_valid=0 one cycle later, and the band index keeps its previous value.
- R3: A strap pair that names a band gives band_valid=1 and code_invalid=0 on the next cycle.
- R4: The pair (M,M) takes the band from measurement. The measured-clock bands are 0: 19.4–20.9 MHz, 1: 38.8–41.7 MHz, 2: 77.7–83.4 MHz, 3: 155.5–167 MHz, 4: 311–334 MHz and 5: 622–667 MHz. A stable input inside a band is reported with band_valid=1 within four gate windows.
- R5: In auto mode, a measured frequency outside every band drives band_valid to 0 and holds the last band index.
- R6: A measured band replaces the current one only after two consecutive gate windows classify to it. No change is visible within half a window of a frequency step.
- R7: With out_mode LOW, mult_factor is 2^(3−band), saturating at 1 for bands 3 to 5.
- R8: With out_mode MID, HIGH or code 3, mult_factor is 2^(5−band); band 5 gives 1.
- R9: Reset forces band_idx=0, band_valid=0, code_invalid=0, mult_factor=0, and restarts the gate window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tb | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| clk_meas | input | 1 | Clock whose frequency is classified |
| rng_sel_a | input | 2 | First range select, tri-level code |
| rng_sel_b | input | 2 | Second range select, tri-level code |
| out_mode | input | 2 | Output range select, tri-level code |
| band_idx | output | 3 | Reported band, 0 (lowest) to 5 |
| band_valid | output | 1 | Band index is trustworthy |
| code_invalid | output | 1 | Strap pair is reserved or undefined |
| mult_factor | output | 6 | Multiplication factor, 1 to 32 |

## Verification
A wrong strap decode shows up at band_idx, or at the flag pair, one cycle after the selects settle. A bad multiplier selection is visible on mult_factor in that same cycle. A fault in the edge tally, the synchronizer or the window comparison shows up as a wrong band or a dropped valid flag, but only after up to four gate windows, so the bench waits for that horizon before it judges. A broken agreement filter shows as an early band change within half a window of a frequency step.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  typedef enum logic [1:0] {
    TL_LOW  = 2'd0,
    TL_MID  = 2'd1,
    TL_HIGH = 2'd2,
    TL_BAD  = 2'd3
  } trilvl_e;

  localparam int NBANDS = 6;
  localparam int BAND_W = 3;

  // Lower edge of each band in kHz, band 0 lowest.
  function automatic longint unsigned band_lo_khz(input int idx);
    case (idx)
      0:       return 64'd19400;
      1:       return 64'd38800;
      2:       return 64'd77700;
      3:       return 64'd155500;
      4:       return 64'd311000;
      default: return 64'd622000;
    endcase
  endfunction

  function automatic longint unsigned band_hi_khz(input int idx);
    case (idx)
      0:       return 64'd20900;
      1:       return 64'd41700;
      2:       return 64'd83400;
      3:       return 64'd167000;
      4:       return 64'd334000;
      default: return 64'd667000;
    endcase
  endfunction

  // Edge count expected in a gate of gate_cyc timebase cycles.
  function automatic longint unsigned khz_to_cnt(input longint unsigned khz,
                                                 input longint unsigned gate_cyc,
                                                 input longint unsigned tb_khz,
                                                 input bit              round_up);
    longint unsigned num;
    num = khz * gate_cyc;
    if (round_up) return (num + tb_khz - 1) / tb_khz;
    return num / tb_khz;
  endfunction

endpackage

// File: rtl/fbd_edge_tally.sv
module fbd_edge_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk_meas,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_q
);

  logic [1:0]       rs_q;
  logic             rs_n;
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_d;
  logic [CNT_W-1:0] gray_d;
  logic             cnt_en;

  always_ff @(posedge clk_meas or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  assign cnt_en = 1'b1;

  always_comb begin
    bin_d  = bin_q;
    gray_d = gray_q;
    if (cnt_en) begin
      bin_d  = bin_q + CNT_W'(1);
      gray_d = bin_d ^ (bin_d >> 1);
    end
  end

  always_ff @(posedge clk_meas or negedge rs_n) begin
    if (!rs_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  // R4: the value crossing domains moves by at most one bit per edge
  a_r4_gray_step: assert property (@(posedge clk_meas) disable iff (!rs_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/fbd_gate_meter.sv
module fbd_gate_meter
  import fbd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int GATE_CYC = 512,
  parameter int TB_KHZ   = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  gray_in,
  output logic [BAND_W-1:0] m_band,
  output logic              m_ok
);

  localparam int GW = $clog2(GATE_CYC);

  logic [CNT_W-1:0]  s1_q, s2_q, bin_now, snap_q, delta;
  logic [GW-1:0]     gcnt_q, gcnt_d;
  logic              gate_done;
  logic              primed_q, primed_d;
  logic [CNT_W-1:0]  snap_d;
  logic [NBANDS-1:0] hit_vec;
  logic              hit;
  logic [BAND_W-1:0] hit_idx;
  logic [BAND_W-1:0] cand_q, cand_d, band_d;
  logic              cand_ok_q, cand_ok_d, ok_d;

  // Two-flop capture of the Gray count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_now[CNT_W-1] = s2_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) bin_now[i] = bin_now[i+1] ^ s2_q[i];
  end

  assign gate_done = (gcnt_q == GW'(GATE_CYC - 1));
  assign delta     = bin_now - snap_q;

  genvar gi;
  generate
    for (gi = 0; gi < NBANDS; gi++) begin : g_win
      localparam logic [CNT_W-1:0] LO =
        CNT_W'(khz_to_cnt(band_lo_khz(gi), GATE_CYC, TB_KHZ, 1'b0));
      localparam logic [CNT_W-1:0] HI =
        CNT_W'(khz_to_cnt(band_hi_khz(gi), GATE_CYC, TB_KHZ, 1'b1));
      assign hit_vec[gi] = (delta >= LO) && (delta <= HI);
    end
  endgenerate

  always_comb begin
    hit     = |hit_vec;
    hit_idx = '0;
    for (int i = NBANDS - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = BAND_W'(i);
  end

  always_comb begin
    gcnt_d    = gate_done ? '0 : gcnt_q + GW'(1);
    snap_d    = snap_q;
    primed_d  = primed_q;
    cand_d    = cand_q;
    cand_ok_d = cand_ok_q;
    band_d    = m_band;
    ok_d      = m_ok;
    if (gate_done) begin
      snap_d   = bin_now;
      primed_d = 1'b1;
      if (primed_q) begin
        if (!hit) begin
          cand_ok_d = 1'b0;
          ok_d      = 1'b0;
        end else begin
          cand_d    = hit_idx;
          cand_ok_d = 1'b1;
          if (cand_ok_q && (cand_q == hit_idx)) begin
            band_d = hit_idx;
            ok_d   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q    <= '0;
      snap_q    <= '0;
      primed_q  <= 1'b0;
      cand_q    <= '0;
      cand_ok_q <= 1'b0;
      m_band    <= '0;
      m_ok      <= 1'b0;
    end else begin
      gcnt_q    <= gcnt_d;
      snap_q    <= snap_d;
      primed_q  <= primed_d;
      cand_q    <= cand_d;
      cand_ok_q <= cand_ok_d;
      m_band    <= band_d;
      m_ok      <= ok_d;
    end
  end

  // R5: a window matching no band clears the measured valid
  a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_done && primed_q && !hit) |=> !m_ok);

  // R6: the measured band moves only at a window end that confirms a candidate
  a_r6_pair_needed: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_band) |-> ($past(gate_done) && $past(cand_ok_q)));

endmodule

// File: rtl/fbd_strap_decode.sv
module fbd_strap_decode
  import fbd_pkg::*;
(
  input  logic [1:0]        sel_a,
  input  logic [1:0]        sel_b,
  output logic [BAND_W-1:0] s_band,
  output logic              s_auto,
  output logic              s_rsvd
);

  always_comb begin
    s_band = '0;
    s_auto = 1'b0;
    s_rsvd = 1'b0;
    unique case ({sel_a, sel_b})
      {TL_HIGH, TL_HIGH}: s_band = 3'd0;
      {TL_HIGH, TL_LOW }: s_band = 3'd1;
      {TL_MID,  TL_HIGH}: s_band = 3'd2;
      {TL_MID,  TL_LOW }: s_band = 3'd3;
      {TL_LOW,  TL_HIGH}: s_band = 3'd4;
      {TL_LOW,  TL_LOW }: s_band = 3'd5;
      {TL_MID,  TL_MID }: s_auto = 1'b1;
      default:            s_rsvd = 1'b1;
    endcase
  end

endmodule

// File: rtl/fbd_band_detect.sv
module fbd_band_detect
  import fbd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int GATE_CYC = 512,
  parameter int TB_KHZ   = 50000,
  parameter int MULT_W   = 6
) (
  input  logic              clk_tb,
  input  logic              rst_n,
  input  logic              clk_meas,
  input  logic [1:0]        rng_sel_a,
  input  logic [1:0]        rng_sel_b,
  input  logic [1:0]        out_mode,
  output logic [BAND_W-1:0] band_idx,
  output logic              band_valid,
  output logic              code_invalid,
  output logic [MULT_W-1:0] mult_factor
);

  localparam logic [BAND_W-1:0] TGT_LOW  = 3'd3;
  localparam logic [BAND_W-1:0] TGT_HIGH = BAND_W'(NBANDS - 1);

  logic [1:0]        rs_q;
  logic              rs_n;
  logic [CNT_W-1:0]  gray_w;
  logic [BAND_W-1:0] m_band, s_band;
  logic              m_ok, s_auto, s_rsvd;
  logic [BAND_W-1:0] band_d, tgt, shamt;
  logic              valid_d, inv_d;
  logic [MULT_W-1:0] mult_d;

  always_ff @(posedge clk_tb or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  fbd_edge_tally #(.CNT_W(CNT_W)) u_tally (
    .clk_meas (clk_meas),
    .rst_n    (rst_n),
    .gray_q   (gray_w)
  );

  fbd_gate_meter #(.CNT_W(CNT_W), .GATE_CYC(GATE_CYC), .TB_KHZ(TB_KHZ)) u_meter (
    .clk     (clk_tb),
    .rst_n   (rs_n),
    .gray_in (gray_w),
    .m_band  (m_band),
    .m_ok    (m_ok)
  );

  fbd_strap_decode u_strap (
    .sel_a  (rng_sel_a),
    .sel_b  (rng_sel_b),
    .s_band (s_band),
    .s_auto (s_auto),
    .s_rsvd (s_rsvd)
  );

  always_comb begin
    band_d  = band_idx;
    valid_d = band_valid;
    inv_d   = 1'b0;
    if (s_rsvd) begin
      valid_d = 1'b0;
      inv_d   = 1'b1;
    end else if (s_auto) begin
      valid_d = m_ok;
      if (m_ok) band_d = m_band;
    end else begin
      band_d  = s_band;
      valid_d = 1'b1;
    end
    tgt    = (out_mode == TL_LOW) ? TGT_LOW : TGT_HIGH;
    shamt  = (band_d >= tgt) ? '0 : tgt - band_d;
    mult_d = MULT_W'(1) << shamt;
  end

  always_ff @(posedge clk_tb or negedge rs_n) begin
    if (!rs_n) begin
      band_idx     <= '0;
      band_valid   <= 1'b0;
      code_invalid <= 1'b0;
      mult_factor  <= '0;
    end else begin
      band_idx     <= band_d;
      band_valid   <= valid_d;
      code_invalid <= inv_d;
      mult_factor  <= mult_d;
    end
  end

  // R2: reserved straps raise the flag, drop valid and freeze the band
  a_r2_rsvd_flags: assert property (@(posedge clk_tb) disable iff (!rs_n)
    s_rsvd |=> (code_invalid && !band_valid));
  a_r2_rsvd_hold: assert property (@(posedge clk_tb) disable iff (!rs_n)
    s_rsvd |=> $stable(band_idx));

  // R3: a decoded strap band appears with valid on the next cycle
  a_r3_strap_valid: assert property (@(posedge clk_tb) disable iff (!rs_n)
    (!s_rsvd && !s_auto) |=> (band_valid && !code_invalid && band_idx == $past(s_band)));

  // R4: an auto-mode result is only reported when the meter vouches for it
  a_r4_auto_follow: assert property (@(posedge clk_tb) disable iff (!rs_n)
    (s_auto && m_ok) |=> (band_valid && band_idx == $past(m_band)));

  // R9: valid and invalid never both set; band index in range
  a_r9_flags_excl: assert property (@(posedge clk_tb) disable iff (!rs_n)
    !(band_valid && code_invalid) && (band_idx < BAND_W'(NBANDS)));

endmodule

// File: tb/fbd_band_detect_bench.sv
`timescale 1ns/1ps
module fbd_band_detect_bench;

  localparam int GATE = 512;

  logic       clk_tb, rst_n, clk_meas;
  logic [1:0] sel_a, sel_b, mode;
  logic [2:0] band;
  logic       valid, inval;
  logic [5:0] mult;

  real  f_mhz;
  int   n_chk, n_fail;
  int   exp_band;

  fbd_band_detect #(.GATE_CYC(GATE)) u_fbd_band_detect (
    .clk_tb       (clk_tb),
    .rst_n        (rst_n),
    .clk_meas     (clk_meas),
    .rng_sel_a    (sel_a),
    .rng_sel_b    (sel_b),
    .out_mode     (mode),
    .band_idx     (band),
    .band_valid   (valid),
    .code_invalid (inval),
    .mult_factor  (mult)
  );

  initial clk_tb = 1'b0;
  always #10 clk_tb = ~clk_tb;

  initial begin
    clk_meas = 1'b0;
    f_mhz    = 155.52;
    forever #(500.0 / f_mhz) clk_meas = ~clk_meas;
  end

  function automatic real lo_mhz(input int b);
    real t[6] = '{19.4, 38.8, 77.7, 155.5, 311.0, 622.0};
    return t[b];
  endfunction
  function automatic real hi_mhz(input int b);
    real t[6] = '{20.9, 41.7, 83.4, 167.0, 334.0, 667.0};
    return t[b];
  endfunction

  // -1 auto, -2 reserved, else band
  function automatic int strap_band(input int a, input int b);
    if (a == 2 && b == 2) return 0;
    if (a == 2 && b == 0) return 1;
    if (a == 1 && b == 2) return 2;
    if (a == 1 && b == 0) return 3;
    if (a == 0 && b == 2) return 4;
    if (a == 0 && b == 0) return 5;
    if (a == 1 && b == 1) return -1;
    return -2;
  endfunction

  function automatic int exp_mult(input int b, input int m);
    int tgt;
    tgt = (m == 0) ? 3 : 5;
    return (b >= tgt) ? 1 : (1 << (tgt - b));
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_tb);
  endtask

  task automatic set_strap(input int a, input int b, input int m);
    @(negedge clk_tb);
    sel_a = 2'(a); sel_b = 2'(b); mode = 2'(m);
  endtask

  task automatic check_all(input string tag, input int eb, input int ev, input int ei, input int m);
    check({tag, " band"},  band,  eb);
    check({tag, " valid"}, valid, ev);
    check({tag, " inval"}, inval, ei);
    check({tag, " mult"},  mult,  exp_mult(eb, m));
  endtask

  task automatic strap_case(input int a, input int b, input int m);
    int sb;
    set_strap(a, b, m);
    cycles(3);
    sb = strap_band(a, b);
    if (sb >= 0) begin
      exp_band = sb;
      check_all("R1 R3 R7 R8 strap", exp_band, 1, 0, m);
    end else if (sb == -2) begin
      check_all("R2 reserved", exp_band, 0, 1, m);
    end
  endtask

  initial begin
    #(190000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; sel_a = 2'd2; sel_b = 2'd2; mode = 2'd0;
    exp_band = 0;
    cycles(5);
    // R9 reset state
    check("R9 band", band, 0);
    check("R9 valid", valid, 0);
    check("R9 inval", inval, 0);
    check("R9 mult", mult, 0);
    @(negedge clk_tb); rst_n = 1'b1;
    cycles(4);

    // Directed strap sweep, low and high output modes
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        if (!(a == 1 && b == 1)) strap_case(a, b, 0);
    strap_case(0, 0, 2);
    strap_case(2, 2, 1);
    strap_case(2, 2, 3);   // R8 mode code 3 acts as high
    strap_case(3, 0, 0);   // R2 undefined code
    strap_case(1, 3, 2);   // R2 undefined code

    // Random strap mix
    for (int i = 0; i < 30; i++) begin
      int a, b;
      a = $urandom % 4; b = $urandom % 4;
      if (a == 1 && b == 1) b = 0;
      strap_case(a, b, $urandom % 4);
    end

    // Auto mode with random in-band frequencies
    for (int i = 0; i < 7; i++) begin
      int bsel, m;
      bsel = (i < 6) ? i : ($urandom % 6);
      m = $urandom % 4;
      f_mhz = lo_mhz(bsel) + (0.2 + 0.6 * real'($urandom % 1000) / 1000.0) *
              (hi_mhz(bsel) - lo_mhz(bsel));
      set_strap(1, 1, m);
      cycles(4 * GATE + 40);
      exp_band = bsel;
      check_all("R4 auto", exp_band, 1, 0, m);
    end

    // R6: step frequency, no change within half a window, then settle
    f_mhz = 160.0;
    cycles(4 * GATE + 40);
    check("R6 pre band", band, 3);
    f_mhz = 40.0;
    cycles(GATE / 2);
    check("R6 hold band", band, 3);
    cycles(4 * GATE);
    check("R6 settled band", band, 1);
    check("R6 settled valid", valid, 1);
    exp_band = 1;

    // R5: frequency between bands
    f_mhz = 100.0;
    cycles(4 * GATE + 40);
    check("R5 miss valid", valid, 0);
    check("R5 miss band", band, 1);

    // R2 after auto: reserved keeps the band
    f_mhz = 80.0;
    cycles(4 * GATE + 40);
    check("R4 auto 80", band, 2);
    exp_band = 2;
    strap_case(0, 1, 0);
    strap_case(2, 1, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule